// File: doc/BRIEF.md
# Bus Error Diagnostic Capture Unit

This unit sits beside the master and target engines of a host bus interface and keeps a record of the first bus error that occurs. The bus engines feed it error strobes for each cause, together with the address, the 4-bit command code and the role and direction of the current transfer. When the first error arrives, the unit latches the transfer address as two register words and builds an attribute word. That word holds the command code, one flag per cause, and a sticky status bit. While the status bit is set, the capture is frozen. Any further error only sets an overflow flag.

Software reads the capture through a small register port with a combinational read path. To re-arm the unit, software writes a one to the clear control bit of the attribute word. The two parity causes are qualified inside the unit. The first is the parity-error report on a mastered transfer, which also needs the parity-response enable. The second is the data parity fault that was seen from the side that received the data.

Top module: `buserr_diag_capture`

## Requirements
- R1: When at least one cause is active on a clock edge while the status bit is clear and no clear is written, the following values are latched at that edge and the status bit (attribute bit 31) is set. Offset 0 takes the upper address bits. Offset 1 takes the lower address bits. Attribute bits 3:0 take the command code. Attribute bits 14:8 take the cause flags.
- R2: An error on an edge where the status bit is already set (and no clear is written) sets the overflow bit (attribute bit 30). The address words, command code and cause flags keep their values. The overflow bit is never set while the status bit is clear.
- R3: A write to offset 2 with data bit 29 set clears the status bit, the overflow bit, both address words, the command code and all cause flags at that edge.
- R4: Attribute bit 29 always reads zero. These writes leave all state unchanged: a write to offset 2 with bit 29 clear, and a write to any other offset.
- R5: All causes active on the capturing edge are recorded together, in this order: split completion discarded (input bit 0, attribute bit 8), unexpected split completion (bit 1, attribute 9), split response time-out (bit 2, attribute 10), split completion error message (bit 3, attribute 11), retry limit exceeded (bit 4, attribute 12).
- R6: The mastered-parity cause (attribute bit 13) is raised only when three inputs are all high: `perr_seen`, `role_master` and `perr_resp_en`. In any other combination it is not an error event.
- R7: The detected-parity cause (attribute bit 14) is raised when `dpar_bad` is high on a master read or a target write. `xfer_read` high means a read. On a master write or a target read, `dpar_bad` is not an error event.
- R8: A clear write on the same edge as an error wins, and nothing is captured. If the error is still present on the next edge, it is captured then.
- R9: After reset, offsets 0, 1 and 2 read zero. Offset 3 always reads zero.
- R10: The address is split at bit DATA_W. Offset 1 holds the low DATA_W bits. Offset 0 holds the remaining upper bits, zero-extended. When ADDR_W is at most DATA_W, offset 0 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| simple_evt | input | 5 | Split and retry cause strobes, bit order as in R5 |
| perr_seen | input | 1 | Parity error report driven or observed |
| dpar_bad | input | 1 | Bad data parity detected on the current data phase |
| role_master | input | 1 | Unit is bus master for the current transfer |
| xfer_read | input | 1 | Current transfer is a read |
| perr_resp_en | input | 1 | Parity-error response enable from the command register |
| bus_addr | input | ADDR_W | Address of the current transfer |
| bus_cmd | input | 4 | Command code of the current transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |

## Verification
The bench builds the unit with a 48-bit address and 32-bit register words. The upper word therefore holds a partial 16-bit field whose top half must read zero, and the variant that keeps upper-word flops is the one built. With this setup, the zero-extension of the upper word can be checked with an all-ones address. The test also reaches the clear-versus-error collision, and every role and direction combination of the two parity causes, in a few dozen cycles.

// File: rtl/buserr_diag_pkg.sv
package buserr_diag_pkg;
   localparam int CMD_W     = 4;
   localparam int NSIMPLE   = 5;
   localparam int NCAUSE    = NSIMPLE + 2;
   localparam int C_DPAR_MS = NSIMPLE;
   localparam int C_DPAR_DT = NSIMPLE + 1;
   localparam int REG_AW    = 2;
   localparam int CAUSE_LSB = 8;
   localparam int CLR_BIT   = 29;
   localparam int OVF_BIT   = 30;
   localparam int ST_BIT    = 31;

   typedef enum logic [REG_AW-1:0] {
      OFS_ADDR_HI = 2'd0,
      OFS_ADDR_LO = 2'd1,
      OFS_ATTR    = 2'd2,
      OFS_SPARE   = 2'd3
   } reg_ofs_e;
endpackage

// File: rtl/buserr_cause_decode.sv
module buserr_cause_decode
   import buserr_diag_pkg::*;
(
   input  logic [NSIMPLE-1:0] simple_i,
   input  logic               perr_seen_i,
   input  logic               dpar_bad_i,
   input  logic               role_master_i,
   input  logic               xfer_read_i,
   input  logic               perr_resp_en_i,
   output logic [NCAUSE-1:0]  cause_o,
   output logic               any_o
);
   genvar gi;
   generate
      for (gi = 0; gi < NSIMPLE; gi++) begin : g_simple
         assign cause_o[gi] = simple_i[gi];
      end
   endgenerate

   // mastered transfer, parity report seen, and response enabled
   assign cause_o[C_DPAR_MS] = perr_seen_i & role_master_i & perr_resp_en_i;
   // receiving side of the data: master on read, target on write
   assign cause_o[C_DPAR_DT] = dpar_bad_i & (role_master_i == xfer_read_i);

   assign any_o = |cause_o;
endmodule

// File: rtl/buserr_capture_bank.sv
module buserr_capture_bank
   import buserr_diag_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              evt_i,
   input  logic [NCAUSE-1:0] cause_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CMD_W-1:0]  cmd_i,
   output logic [DATA_W-1:0] hi_o,
   output logic [DATA_W-1:0] lo_o,
   output logic [CMD_W-1:0]  cmd_o,
   output logic [NCAUSE-1:0] cause_o,
   output logic              st_o,
   output logic              ovf_o
);
   localparam int EXT_W = 2 * DATA_W;

   logic [EXT_W-1:0] addr_ext;
   logic             take;

   assign addr_ext = EXT_W'(addr_i);
   assign take     = evt_i & ~st_o & ~clr_i;

   // sticky status and overflow
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_o  <= 1'b0;
         ovf_o <= 1'b0;
      end else if (clr_i) begin
         st_o  <= 1'b0;
         ovf_o <= 1'b0;
      end else if (evt_i) begin
         if (st_o) ovf_o <= 1'b1;
         else      st_o  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_o  <= '0;
         cmd_o <= '0;
      end else if (clr_i) begin
         lo_o  <= '0;
         cmd_o <= '0;
      end else if (take) begin
         lo_o  <= addr_ext[DATA_W-1:0];
         cmd_o <= cmd_i;
      end
   end

   genvar gi;
   generate
      if (ADDR_W > DATA_W) begin : g_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hi_o <= '0;
            else if (clr_i)  hi_o <= '0;
            else if (take)   hi_o <= addr_ext[EXT_W-1:DATA_W];
         end
      end else begin : g_no_hi
         logic unused_hi;
         assign unused_hi = ^addr_ext[EXT_W-1:DATA_W];
         assign hi_o      = '0;
      end

      for (gi = 0; gi < NCAUSE; gi++) begin : g_cause
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cause_o[gi] <= 1'b0;
            else if (clr_i)  cause_o[gi] <= 1'b0;
            else if (take)   cause_o[gi] <= cause_i[gi];
         end
      end
   endgenerate
endmodule

// File: rtl/buserr_read_mux.sv
module buserr_read_mux
   import buserr_diag_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input  logic [REG_AW-1:0] sel_i,
   input  logic [DATA_W-1:0] hi_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] attr_i,
   output logic [DATA_W-1:0] rdata_o
);
   always_comb begin
      unique case (reg_ofs_e'(sel_i))
         OFS_ADDR_HI: rdata_o = hi_i;
         OFS_ADDR_LO: rdata_o = lo_i;
         OFS_ATTR:    rdata_o = attr_i;
         default:     rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/buserr_diag_capture.sv
module buserr_diag_capture
   import buserr_diag_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSIMPLE-1:0] simple_evt,
   input  logic               perr_seen,
   input  logic               dpar_bad,
   input  logic               role_master,
   input  logic               xfer_read,
   input  logic               perr_resp_en,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CMD_W-1:0]   bus_cmd,
   input  logic               reg_wr,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata
);
   generate
      if (DATA_W < ST_BIT + 1) begin : g_bad_dw
         $error("DATA_W must hold the attribute layout (at least 32)");
      end
      if (ADDR_W < 1 || ADDR_W > 2 * DATA_W) begin : g_bad_aw
         $error("ADDR_W must lie between 1 and 2*DATA_W");
      end
   endgenerate

   logic [NCAUSE-1:0] cause_vec;
   logic [NCAUSE-1:0] cause_q;
   logic              err_any;
   logic              clr;
   logic              st_q;
   logic              ovf_q;
   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] lo_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [DATA_W-1:0] attr_word;

   assign clr = reg_wr && (reg_addr == OFS_ATTR) && reg_wdata[CLR_BIT];

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   buserr_cause_decode u_dec (
      .simple_i       (simple_evt),
      .perr_seen_i    (perr_seen),
      .dpar_bad_i     (dpar_bad),
      .role_master_i  (role_master),
      .xfer_read_i    (xfer_read),
      .perr_resp_en_i (perr_resp_en),
      .cause_o        (cause_vec),
      .any_o          (err_any)
   );

   buserr_capture_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .evt_i   (err_any),
      .cause_i (cause_vec),
      .addr_i  (bus_addr),
      .cmd_i   (bus_cmd),
      .hi_o    (hi_q),
      .lo_o    (lo_q),
      .cmd_o   (cmd_q),
      .cause_o (cause_q),
      .st_o    (st_q),
      .ovf_o   (ovf_q)
   );

   // clear bit position is left at zero so it always reads back low
   always_comb begin
      attr_word                         = '0;
      attr_word[CMD_W-1:0]              = cmd_q;
      attr_word[CAUSE_LSB +: NCAUSE]    = cause_q;
      attr_word[OVF_BIT]                = ovf_q;
      attr_word[ST_BIT]                 = st_q;
   end

   buserr_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .sel_i   (reg_addr),
      .hi_i    (hi_q),
      .lo_i    (lo_q),
      .attr_i  (attr_word),
      .rdata_o (reg_rdata)
   );
endmodule

// File: rtl/buserr_diag_checker.sv
module buserr_diag_checker
   import buserr_diag_pkg::*;
#(
   parameter int DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              role_master,
   input logic              perr_resp_en,
   input logic              evt,
   input logic [NCAUSE-1:0] causes,
   input logic              st,
   input logic              ovf,
   input logic [DATA_W-1:0] hi_q,
   input logic [DATA_W-1:0] lo_q,
   input logic [CMD_W-1:0]  cmd_q,
   input logic [NCAUSE-1:0] cause_q
);
   logic wr_clr;
   assign wr_clr = reg_wr && (reg_addr == OFS_ATTR) && reg_wdata[CLR_BIT];

   p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!st && !wr_clr && evt) |=> st);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st && !wr_clr && evt) |=> ($stable(hi_q) && $stable(lo_q) &&
                                  $stable(cmd_q) && $stable(cause_q)));

   p_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st && !wr_clr && evt) |=> ovf);

   p_ovf_needs_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> st);

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (!st && !ovf && hi_q == '0 && lo_q == '0 &&
                  cmd_q == '0 && cause_q == '0));

   p_clr_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == OFS_ATTR) |-> !reg_rdata[CLR_BIT]);

   p_all_causes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!st && !wr_clr && evt) |=> (cause_q == $past(causes)));

   p_dpar_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!st && !wr_clr && evt && !(role_master && perr_resp_en)) |=> !cause_q[C_DPAR_MS]);

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && evt) |=> !st);
endmodule

bind buserr_diag_capture buserr_diag_checker #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .role_master  (role_master),
   .perr_resp_en (perr_resp_en),
   .evt          (err_any),
   .causes       (cause_vec),
   .st           (st_q),
   .ovf          (ovf_q),
   .hi_q         (hi_q),
   .lo_q         (lo_q),
   .cmd_q        (cmd_q),
   .cause_q      (cause_q)
);

// File: tb/buserr_diag_capture_test.sv
module buserr_diag_capture_test;
   localparam int AW = 48;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [4:0]    simple_evt;
   logic          perr_seen, dpar_bad, role_master, xfer_read, perr_resp_en;
   logic [AW-1:0] bus_addr;
   logic [3:0]    bus_cmd;
   logic          reg_wr;
   logic [1:0]    reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [DW-1:0] reg_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference state
   logic [31:0] m_hi, m_lo;
   logic [3:0]  m_cmd;
   logic [6:0]  m_cause;
   logic        m_st, m_ov;

   always #5 clk = ~clk;

   buserr_diag_capture #(.ADDR_W(AW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .simple_evt(simple_evt), .perr_seen(perr_seen),
      .dpar_bad(dpar_bad), .role_master(role_master), .xfer_read(xfer_read),
      .perr_resp_en(perr_resp_en), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic idle();
      simple_evt = '0; perr_seen = 0; dpar_bad = 0; role_master = 0;
      xfer_read = 0; perr_resp_en = 0; bus_cmd = '0; bus_addr = '0;
      reg_wr = 0; reg_addr = '0; reg_wdata = '0;
   endtask

   function automatic logic [31:0] expect_word(input int sel);
      logic [31:0] w;
      w = '0;
      case (sel)
         0: w = m_hi;
         1: w = m_lo;
         2: begin
            w[3:0]  = m_cmd;
            w[14:8] = m_cause;
            w[30]   = m_ov;
            w[31]   = m_st;
         end
         default: w = '0;
      endcase
      return w;
   endfunction

   task automatic check_all(input string tag);
      for (int s = 0; s < 4; s++) begin
         reg_addr = s[1:0];
         #1;
         checks++;
         if (reg_rdata !== expect_word(s)) begin
            fails++;
            $display("FAIL %s offset %0d: got %h expected %h", tag, s, reg_rdata, expect_word(s));
         end
      end
   endtask

   // one clock: reference update from the inputs held across the edge, then compare
   task automatic step(input string tag);
      logic [6:0] c;
      logic       wclr;
      @(posedge clk);
      c[4:0] = simple_evt;
      c[5]   = perr_seen && role_master && perr_resp_en;
      c[6]   = dpar_bad && ((role_master && xfer_read) || (!role_master && !xfer_read));
      wclr   = reg_wr && reg_addr == 2'd2 && reg_wdata[29];
      if (wclr) begin
         m_hi = '0; m_lo = '0; m_cmd = '0; m_cause = '0; m_st = 0; m_ov = 0;
      end else if (c != 0) begin
         if (m_st) m_ov = 1'b1;
         else begin
            m_st = 1'b1;
            m_hi = 32'(bus_addr >> 32);
            m_lo = bus_addr[31:0];
            m_cmd = bus_cmd;
            m_cause = c;
         end
      end
      #2;
      idle();
      check_all(tag);
   endtask

   task automatic do_clear(input string tag);
      reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h2000_0000;
      step(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      m_hi = '0; m_lo = '0; m_cmd = '0; m_cause = '0; m_st = 0; m_ov = 0;
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #2 check_all("R9 in reset");
      @(negedge clk) rst_n = 1;
      step("R9 after reset");

      // R4: write of zero to the attribute word does nothing
      reg_wr = 1; reg_addr = 2'd2; reg_wdata = '0;
      step("R4 zero write");

      // R1: first error captured (timeout cause, command 7)
      simple_evt = 5'b00100; bus_addr = 48'hABCD_1234_5678; bus_cmd = 4'h7;
      step("R1 capture");

      // R2: second error only sets overflow
      simple_evt = 5'b00001; bus_addr = 48'h1111_2222_3333; bus_cmd = 4'h3;
      step("R2 overflow");

      // R4: clear bit written to another offset is ignored
      reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'hFFFF_FFFF;
      step("R4 other offset");
      // R4: all bits but the clear bit written at attribute offset
      reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'hDFFF_FFFF;
      step("R4 clear bit low");

      do_clear("R3 clear");

      // R5: every cause at once
      simple_evt = 5'b11111; perr_seen = 1; role_master = 1; perr_resp_en = 1;
      xfer_read = 1; dpar_bad = 1; bus_addr = 48'h0000_8765_4321; bus_cmd = 4'hC;
      step("R5 all causes");
      do_clear("R3 clear");
      simple_evt = 5'b01010; bus_addr = 48'h0042_0000_0001; bus_cmd = 4'h1;
      step("R5 two causes");
      do_clear("R3 clear");

      // R6: mastered-parity gating
      perr_seen = 1; role_master = 0; perr_resp_en = 1;
      step("R6 not master");
      perr_seen = 1; role_master = 1; perr_resp_en = 0;
      step("R6 enable off");
      perr_seen = 1; role_master = 1; perr_resp_en = 1; xfer_read = 1;
      bus_addr = 48'h0001_0000_00F0; bus_cmd = 4'h6;
      step("R6 gated capture");
      do_clear("R3 clear");

      // R7: detected-parity by role and direction
      dpar_bad = 1; role_master = 1; xfer_read = 0;
      step("R7 master write");
      dpar_bad = 1; role_master = 0; xfer_read = 1;
      step("R7 target read");
      dpar_bad = 1; role_master = 0; xfer_read = 0; bus_addr = 48'h0000_0000_0ABC; bus_cmd = 4'h7;
      step("R7 target write");
      do_clear("R3 clear");
      dpar_bad = 1; role_master = 1; xfer_read = 1; bus_addr = 48'h0000_0000_0DEF; bus_cmd = 4'h6;
      step("R7 master read");
      do_clear("R3 clear");

      // R8: clear and error on one edge, error persists one more edge
      reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h2000_0000;
      simple_evt = 5'b10000; bus_addr = 48'h0000_5555_AAAA; bus_cmd = 4'h2;
      step("R8 collision");
      simple_evt = 5'b10000; bus_addr = 48'h0000_5555_AAAA; bus_cmd = 4'h2;
      step("R8 next edge capture");
      do_clear("R3 clear");

      // R10: all-ones address, upper word zero-extended
      simple_evt = 5'b00010; bus_addr = {AW{1'b1}}; bus_cmd = 4'hF;
      step("R10 address split");
      simple_evt = 5'b00100; perr_seen = 1; role_master = 1; perr_resp_en = 1;
      step("R2 overflow held");
      do_clear("R3 clear");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule